// File: doc/BRIEF.md
# Emergency Erase Trigger Qualifier

This block watches an active-low emergency-erase pin and decides whether a press of that pin should start a secure erase, and how deep that erase goes. The pin is resynchronised into the clock domain and passed through a debounce filter. A free-running tick divider then times how long the filtered pin stays low. The design is parameterised, so simulation can use a short tick period and small thresholds in place of whole seconds.

A press shorter than the data threshold is treated as an accident and produces nothing. A press that lasts at least the data threshold but is released before the full threshold asks for a data erase, in which user data is cleared and filled with all ones. A press that reaches the full threshold asks for a full erase that also removes the firmware region. The full-level decision is taken as soon as the threshold is crossed, without waiting for release.

A qualified request is accepted only if the host-transfer activity allows it. In master role, the only blocking case is a read and a write that are both active. In slave role, any active transfer blocks the request. An accepted request gives a one-cycle pulse with a level code. A blocked request gives a one-cycle refusal pulse and is discarded.

Top module: `erase_trigger_qual`

## Requirements
- R1: After reset, erase_req, erase_refused and erase_level are all 0.
- R2: A filtered low hold of fewer than DATA_TICKS timebase ticks produces neither erase_req nor erase_refused.
- R3: A hold of at least DATA_TICKS ticks that is released before FULL_TICKS ticks produces exactly one erase_req with erase_level = 2'b01 (data erase).
- R4: A hold that reaches FULL_TICKS ticks produces exactly one erase_req with erase_level = 2'b10 (data plus firmware). The pulse appears while the pin is still held low.
- R5: erase_level uses the encoding 00 none, 01 data, 10 data plus firmware. It is 2'b00 in every cycle in which erase_req is low, and it is never 2'b11.
- R6: With role_master = 1, a qualified press is refused when rd_active and wr_active are both 1. It is accepted when only one of them is 1, or when neither is.
- R7: With role_master = 0, a qualified press is accepted only when rd_active and wr_active are both 0. Otherwise it is refused.
- R8: A refused press gives exactly one erase_refused pulse and no erase_req. No erase_req follows later, even after the activity clears.
- R9: A pin change that lasts fewer than DEBOUNCE_CYCLES clock cycles is ignored. This covers both a short low glitch while idle and a short high blip during a hold.
- R10: erase_req and erase_refused are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_pin_n | input | 1 | Asynchronous emergency-erase pin, low = pressed |
| role_master | input | 1 | 1 = drive is master, 0 = slave |
| rd_active | input | 1 | A host read transfer is in progress |
| wr_active | input | 1 | A host write transfer is in progress |
| erase_req | output | 1 | One-cycle pulse: erase request accepted |
| erase_level | output | 2 | Level code of the accepted request, valid with erase_req |
| erase_refused | output | 1 | One-cycle pulse: qualified press refused because of activity |

## Verification
Two things can land in the same cycle: the classification decision and a change of the activity inputs. The gate samples the activity only in the decision cycle, so an activity change that comes just after that cycle must not bring a refused press back to life. The bench provokes this by holding both transfers active through a release, then clearing them once the decision has been taken. It judges the result by the single refusal pulse and by the absence of any later request. The full-threshold decision is judged in a similar way: the bench records whether the request pulse arrived while the pin was still held low.

// File: rtl/etq_pkg.sv
package etq_pkg;
   typedef enum logic [1:0] {
      LVL_NONE = 2'b00,
      LVL_DATA = 2'b01,
      LVL_FULL = 2'b10
   } erase_lvl_e;

   typedef enum logic [1:0] {
      TS_IDLE   = 2'b00,
      TS_TIMING = 2'b01,
      TS_LATCH  = 2'b10
   } timer_state_e;
endpackage

// File: rtl/etq_pin_filter.sv
module etq_pin_filter #(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pressed
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (DEBOUNCE_CYCLES == 0) begin : g_nodeb
         assign filt_q = synced;
      end else begin : g_deb
         localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
         logic [CW-1:0] cnt_q;
         logic          lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b1;
            end else if (synced == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(DEBOUNCE_CYCLES - 1)) begin
               cnt_q <= '0;
               lvl_q <= synced;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign filt_q = lvl_q;
      end
   endgenerate

   assign pressed = ~filt_q;
endmodule

// File: rtl/etq_tick_gen.sv
module etq_tick_gen #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          div_q <= '0;
            else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
            else                                 div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/etq_hold_timer.sv
module etq_hold_timer
   import etq_pkg::*;
#(
   parameter int DATA_TICKS = 3,
   parameter int FULL_TICKS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pressed,
   input  logic       tick,
   output logic       decide,
   output erase_lvl_e level
);
   localparam int TW = $clog2(FULL_TICKS + 1);

   timer_state_e  st_q;
   logic [TW-1:0] ticks_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TS_IDLE;
         ticks_q <= '0;
         decide  <= 1'b0;
         level   <= LVL_NONE;
      end else begin
         decide <= 1'b0;
         level  <= LVL_NONE;
         unique case (st_q)
            TS_IDLE: begin
               ticks_q <= '0;
               if (pressed) st_q <= TS_TIMING;
            end
            TS_TIMING: begin
               if (!pressed) begin
                  st_q <= TS_IDLE;
                  if (ticks_q >= TW'(DATA_TICKS)) begin
                     decide <= 1'b1;
                     level  <= LVL_DATA;
                  end
               end else if (tick) begin
                  if (ticks_q == TW'(FULL_TICKS - 1)) begin
                     decide <= 1'b1;
                     level  <= LVL_FULL;
                     st_q   <= TS_LATCH;
                  end else begin
                     ticks_q <= ticks_q + 1'b1;
                  end
               end
            end
            TS_LATCH: begin
               if (!pressed) st_q <= TS_IDLE;
            end
            default: st_q <= TS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/erase_trigger_qual.sv
module erase_trigger_qual
   import etq_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 4,
   parameter int TICK_DIV        = 4,
   parameter int DATA_TICKS      = 3,
   parameter int FULL_TICKS      = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       erase_pin_n,
   input  logic       role_master,
   input  logic       rd_active,
   input  logic       wr_active,
   output logic       erase_req,
   output logic [1:0] erase_level,
   output logic       erase_refused
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (DATA_TICKS < 1 || FULL_TICKS <= DATA_TICKS) begin : g_bad_thr
         $error("need 1 <= DATA_TICKS < FULL_TICKS");
      end
   endgenerate

   logic       pressed;
   logic       tick;
   logic       decide;
   erase_lvl_e level;
   logic       allowed;

   etq_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filter (
      .clk(clk), .rst_n(rst_n), .pin_n(erase_pin_n), .pressed(pressed)
   );

   etq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   etq_hold_timer #(.DATA_TICKS(DATA_TICKS), .FULL_TICKS(FULL_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .pressed(pressed), .tick(tick),
      .decide(decide), .level(level)
   );

   // master: blocked only by simultaneous read and write; slave: by any transfer
   assign allowed = role_master ? ~(rd_active & wr_active) : ~(rd_active | wr_active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_req     <= 1'b0;
         erase_refused <= 1'b0;
         erase_level   <= LVL_NONE;
      end else begin
         erase_req     <= decide & allowed;
         erase_refused <= decide & ~allowed;
         erase_level   <= (decide & allowed) ? level : LVL_NONE;
      end
   end
endmodule

// File: rtl/etq_checker.sv
module etq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       role_master,
   input logic       rd_active,
   input logic       wr_active,
   input logic       erase_req,
   input logic [1:0] erase_level,
   input logic       erase_refused
);
   p_req_ref_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_req && erase_refused));

   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);

   p_ref_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      erase_refused |=> !erase_refused);

   p_level_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_req |-> erase_level == 2'b00);

   p_level_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (erase_level == 2'b01 || erase_level == 2'b10));

   p_master_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && $past(role_master)) |-> !($past(rd_active) && $past(wr_active)));

   p_slave_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !$past(role_master)) |-> (!$past(rd_active) && !$past(wr_active)));
endmodule

bind erase_trigger_qual etq_checker u_etq_checker (
   .clk(clk), .rst_n(rst_n), .role_master(role_master),
   .rd_active(rd_active), .wr_active(wr_active),
   .erase_req(erase_req), .erase_level(erase_level), .erase_refused(erase_refused)
);

// File: tb/tb_erase_trigger_qual.sv
module tb_erase_trigger_qual;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       erase_pin_n = 1'b1;
   logic       role_master = 1'b1;
   logic       rd_active = 1'b0;
   logic       wr_active = 1'b0;
   logic       erase_req;
   logic [1:0] erase_level;
   logic       erase_refused;

   int checks = 0;
   int fails = 0;
   int req_cnt = 0;
   int ref_cnt = 0;
   int stray_lvl = 0;
   logic [1:0] lvl_seen = 2'b00;
   bit req_while_low = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   erase_trigger_qual dut (
      .clk(clk), .rst_n(rst_n), .erase_pin_n(erase_pin_n),
      .role_master(role_master), .rd_active(rd_active), .wr_active(wr_active),
      .erase_req(erase_req), .erase_level(erase_level), .erase_refused(erase_refused)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (erase_req) begin
            req_cnt++;
            lvl_seen = erase_level;
            if (!erase_pin_n) req_while_low = 1'b1;
         end
         if (erase_refused) ref_cnt++;
         if (!erase_req && erase_level != 2'b00) stray_lvl++;
      end
   end

   // hold cycles, master, rd, wr, expected reqs, expected level, expected refusals
   typedef struct packed {
      logic [7:0] hold;
      logic       mst;
      logic       rd;
      logic       wr;
      logic [1:0] n_req;
      logic [1:0] lvl;
      logic [1:0] n_ref;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{8'd6,  1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 2'd0},  // R2 short press
      '{8'd18, 1'b1, 1'b0, 1'b0, 2'd1, 2'b01, 2'd0},  // R3 data, master idle
      '{8'd26, 1'b0, 1'b0, 1'b0, 2'd1, 2'b01, 2'd0},  // R3 R7 data, slave idle
      '{8'd60, 1'b1, 1'b0, 1'b0, 2'd1, 2'b10, 2'd0},  // R4 full
      '{8'd20, 1'b1, 1'b1, 1'b0, 2'd1, 2'b01, 2'd0},  // R6 read only
      '{8'd20, 1'b1, 1'b0, 1'b1, 2'd1, 2'b01, 2'd0},  // R6 write only
      '{8'd20, 1'b1, 1'b1, 1'b1, 2'd0, 2'b00, 2'd1},  // R6 R8 both
      '{8'd20, 1'b0, 1'b1, 1'b0, 2'd0, 2'b00, 2'd1},  // R7 slave read
      '{8'd20, 1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 2'd1},  // R7 slave write
      '{8'd60, 1'b0, 1'b1, 1'b1, 2'd0, 2'b00, 2'd1},  // R7 full refused
      '{8'd60, 1'b1, 1'b1, 1'b1, 2'd0, 2'b00, 2'd1},  // R6 full refused
      '{8'd6,  1'b1, 1'b1, 1'b1, 2'd0, 2'b00, 2'd0}   // R2 short, busy
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      req_cnt = 0; ref_cnt = 0; lvl_seen = 2'b00; req_while_low = 1'b0;
   endtask

   task automatic press(input int hold);
      @(posedge clk); #1 erase_pin_n = 1'b0;
      repeat (hold) @(posedge clk);
      #1 erase_pin_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(erase_req == 1'b0, "R1 erase_req", int'(erase_req), 0);
      check(erase_refused == 1'b0, "R1 erase_refused", int'(erase_refused), 0);
      check(erase_level == 2'b00, "R1 erase_level", int'(erase_level), 0);
      repeat (10) @(posedge clk);

      foreach (VECS[i]) begin
         clear_counts();
         #1 role_master = VECS[i].mst; rd_active = VECS[i].rd; wr_active = VECS[i].wr;
         press(int'(VECS[i].hold));
         repeat (40) @(posedge clk);
         check(req_cnt == int'(VECS[i].n_req), $sformatf("R3/R4/R6/R7 vec%0d req count", i),
               req_cnt, int'(VECS[i].n_req));
         check(lvl_seen == VECS[i].lvl, $sformatf("R5 vec%0d level", i),
               int'(lvl_seen), int'(VECS[i].lvl));
         check(ref_cnt == int'(VECS[i].n_ref), $sformatf("R8 vec%0d refused count", i),
               ref_cnt, int'(VECS[i].n_ref));
         if (VECS[i].lvl == 2'b10)
            check(req_while_low, $sformatf("R4 vec%0d early full decision", i),
                  int'(req_while_low), 1);
         #1 rd_active = 1'b0; wr_active = 1'b0;
         repeat (5) @(posedge clk);
      end

      // R8: refused press is not retried once activity clears
      clear_counts();
      #1 role_master = 1'b1; rd_active = 1'b1; wr_active = 1'b1;
      press(20);
      repeat (20) @(posedge clk);
      #1 rd_active = 1'b0; wr_active = 1'b0;
      repeat (80) @(posedge clk);
      check(ref_cnt == 1, "R8 single refusal", ref_cnt, 1);
      check(req_cnt == 0, "R8 no later request", req_cnt, 0);

      // R9: short low glitch ignored
      clear_counts();
      press(2);
      repeat (60) @(posedge clk);
      check(req_cnt == 0 && ref_cnt == 0, "R9 glitch ignored", req_cnt + ref_cnt, 0);

      // R9: short high blip inside a data-length hold does not split the press
      clear_counts();
      press(10);
      repeat (2) @(posedge clk);
      #1 erase_pin_n = 1'b0;
      repeat (10) @(posedge clk);
      #1 erase_pin_n = 1'b1;
      repeat (40) @(posedge clk);
      check(req_cnt == 1, "R9 blip single request", req_cnt, 1);
      check(lvl_seen == 2'b01, "R9 blip data level", int'(lvl_seen), 1);

      // R5 level stays 00 outside request cycles, across the whole run
      check(stray_lvl == 0, "R5 stray level", stray_lvl, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule